// File: doc/BRIEF.md
# CAN Message Object Allocator

This block owns four message objects for a CAN controller. When the protocol engine reports a finished, already-accepted frame, the block picks the object that stores it. When objects are waiting to send, it names the one the engine should send next. Each object holds an enable bit, a direction bit, a buffer-member bit and an identifier. Software reaches these fields for one object at a time, through a page register and a small register window.

Receive objects that are not buffer members act as dedicated receivers for one exact identifier. Buffer members take any frame that no dedicated receiver claims. They can be any subset of the objects, and their numbers need not be adjacent. Every object that stores a frame disables itself. When the last enabled member is used, the buffer counts as full: a sticky interrupt rises and frames meant for the buffer are dropped. This lasts until software enables a member again.

A 16-bit timer runs only while the global enable is set. Its value is captured into a stamp register for every received frame and for every sent frame.

Top module: `can_mob_alloc`

## Requirements
- R1: After reset the page is 0, every object field is 0, the global enable and the interrupt are 0, the timer reads 0 and tx_req_o is low.
- R2: Register window addresses: 0 is the page (selects the object for addresses 1 and 2). 1 is the object control, with bit 0 enable, bit 1 direction (1 = transmit) and bit 2 buffer member. 2 is the object identifier. 3 is global, with bit 0 enable and bit 1 the interrupt flag. 4 is the last stamp and 5 is the live timer. Reads are combinational.
- R3: The timer reads 0 while the global enable is low. While the enable is high it advances by one each cycle, and it wraps from 0xFFFF to 0.
- R4: On a cycle with rx_done_i, or with tx_done_i while a transmit is pending, the timer value of that cycle is captured into the stamp register.
- R5: A frame goes to a dedicated receiver when one matches. Such an object is enabled, receives, is not a member, and has an identifier equal to rx_id_i. The lowest-numbered match wins, and it takes precedence over any buffer member.
- R6: A frame with no dedicated match goes to the lowest-numbered enabled receiving buffer member. Members need not be adjacent.
- R7: Storing a frame clears that object's enable bit and writes rx_id_i into its identifier. In the next cycle rx_store_o pulses for one cycle, with rx_obj_o giving the object number.
- R8: When the only remaining enabled member stores a frame, irq_o sets and stays set. Writing 1 to global bit 1 clears it. A fill in the same cycle as the clear wins.
- R9: While no member is enabled, frames without a dedicated match are dropped. There is no rx_store_o and no field changes. After software re-enables one member, that member takes the next such frame.
- R10: tx_req_o is high when some object has enable and transmit direction set. tx_obj_o is the lowest such object, and tx_id_o is its identifier. tx_done_i clears that object's enable.
- R11: A frame stored by a dedicated receiver never sets irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 16 | Register read data |
| rx_done_i | input | 1 | Accepted frame finished |
| rx_id_i | input | 11 | Identifier of that frame |
| rx_store_o | output | 1 | Frame stored, one-cycle pulse |
| rx_obj_o | output | 2 | Object that stored it |
| tx_req_o | output | 1 | An object is waiting to send |
| tx_obj_o | output | 2 | Object selected to send |
| tx_id_o | output | 11 | Identifier of the selected object |
| tx_done_i | input | 1 | Selected object has been sent |
| irq_o | output | 1 | Sticky buffer-full interrupt |

## Verification
The first frame's identifier matches a dedicated receiver while a lower-numbered buffer member is also enabled. This shows that a dedicated match beats object number. Later frames have unmatched identifiers and fill members 0 and 2 in turn, showing lowest-first order across a gap and the single interrupt on the last fill. Frames sent to a full buffer must leave no trace. A frame sent after one member is re-enabled must land there, which separates real blocking from plain lowest-first selection. Two pending transmitters check the send order. Stamps taken at known timer reads, plus a full timer lap, cover capture and wrap.

// File: rtl/can_mob_pkg.sv
`timescale 1ns/1ps
package can_mob_pkg;
  typedef enum logic [2:0] {
    A_PAGE = 3'd0,
    A_CTRL = 3'd1,
    A_ID   = 3'd2,
    A_GLB  = 3'd3,
    A_STMP = 3'd4,
    A_TIME = 3'd5
  } reg_addr_e;

  localparam int unsigned CB_EN  = 0;
  localparam int unsigned CB_DIR = 1;
  localparam int unsigned CB_MBR = 2;
  localparam int unsigned GB_EN  = 0;
  localparam int unsigned GB_IRQ = 1;
endpackage

// File: rtl/can_mob_prio.sv
`timescale 1ns/1ps
// lowest index wins
module can_mob_prio #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  gnt_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o    = IW'(i);
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_mob_timer.sv
`timescale 1ns/1ps
module can_mob_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [TW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= cnt_o + TW'(1);
    else           cnt_o <= '0;
  end
endmodule

// File: rtl/can_mob_objs.sv
`timescale 1ns/1ps
module can_mob_objs #(
  parameter int unsigned N   = 4,
  parameter int unsigned IDW = 11,
  parameter int unsigned IW  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IW-1:0]           page_i,
  input  logic                    wr_ctrl_i,
  input  logic [2:0]              ctrl_i,
  input  logic                    wr_id_i,
  input  logic [IDW-1:0]          id_i,
  input  logic                    rx_take_i,
  input  logic [IW-1:0]           rx_idx_i,
  input  logic [IDW-1:0]          rx_id_i,
  input  logic                    tx_clr_i,
  input  logic [IW-1:0]           tx_idx_i,
  output logic [N-1:0]            en_o,
  output logic [N-1:0]            dir_o,
  output logic [N-1:0]            mbr_o,
  output logic [N-1:0][IDW-1:0]   id_o
);
  import can_mob_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_obj
    logic sel_pg, hit_rx, hit_tx;
    assign sel_pg = (page_i == IW'(g));
    assign hit_rx = rx_take_i && (rx_idx_i == IW'(g));
    assign hit_tx = tx_clr_i && (tx_idx_i == IW'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[g]  <= 1'b0;
        dir_o[g] <= 1'b0;
        mbr_o[g] <= 1'b0;
        id_o[g]  <= '0;
      end else begin
        if (hit_rx) begin
          en_o[g] <= 1'b0;
          id_o[g] <= rx_id_i;
        end
        if (hit_tx) en_o[g] <= 1'b0;
        // software write lands last
        if (wr_ctrl_i && sel_pg) begin
          en_o[g]  <= ctrl_i[CB_EN];
          dir_o[g] <= ctrl_i[CB_DIR];
          mbr_o[g] <= ctrl_i[CB_MBR];
        end
        if (wr_id_i && sel_pg) id_o[g] <= id_i;
      end
    end
  end
endmodule

// File: rtl/can_mob_alloc.sv
`timescale 1ns/1ps
module can_mob_alloc #(
  parameter int unsigned N_OBJ = 4,
  parameter int unsigned IDW   = 11,
  parameter int unsigned DW    = 16,
  parameter int unsigned TW    = 16,
  localparam int unsigned IW   = (N_OBJ > 1) ? $clog2(N_OBJ) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [2:0]     wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic [2:0]     rd_addr_i,
  output logic [DW-1:0]  rd_data_o,
  input  logic           rx_done_i,
  input  logic [IDW-1:0] rx_id_i,
  output logic           rx_store_o,
  output logic [IW-1:0]  rx_obj_o,
  output logic           tx_req_o,
  output logic [IW-1:0]  tx_obj_o,
  output logic [IDW-1:0] tx_id_o,
  input  logic           tx_done_i,
  output logic           irq_o
);
  import can_mob_pkg::*;

  logic [IW-1:0]            page_q;
  logic                     glb_en_q;
  logic                     irq_q;
  logic [TW-1:0]            stamp_q;
  logic [TW-1:0]            ts;
  logic [N_OBJ-1:0]         obj_en, obj_dir, obj_mbr;
  logic [N_OBJ-1:0][IDW-1:0] obj_id;
  logic [N_OBJ-1:0]         ded_req, mbr_req, tx_rq;
  logic [N_OBJ-1:0]         ded_gnt, mbr_gnt, tx_gnt;
  logic                     ded_any, mbr_any, tx_any;
  logic [IW-1:0]            ded_idx, mbr_idx, tx_idx;
  logic                     wr_page, wr_ctrl, wr_id, wr_glb;
  logic                     rx_take, fill_evt, tx_clr;
  logic [IW-1:0]            rx_idx;

  assign wr_page = wr_en_i && (wr_addr_i == A_PAGE);
  assign wr_ctrl = wr_en_i && (wr_addr_i == A_CTRL);
  assign wr_id   = wr_en_i && (wr_addr_i == A_ID);
  assign wr_glb  = wr_en_i && (wr_addr_i == A_GLB);

  can_mob_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (glb_en_q),
    .cnt_o (ts)
  );

  can_mob_objs #(.N(N_OBJ), .IDW(IDW), .IW(IW)) u_objs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .page_i   (page_q),
    .wr_ctrl_i(wr_ctrl),
    .ctrl_i   (wr_data_i[2:0]),
    .wr_id_i  (wr_id),
    .id_i     (wr_data_i[IDW-1:0]),
    .rx_take_i(rx_take),
    .rx_idx_i (rx_idx),
    .rx_id_i  (rx_id_i),
    .tx_clr_i (tx_clr),
    .tx_idx_i (tx_idx),
    .en_o     (obj_en),
    .dir_o    (obj_dir),
    .mbr_o    (obj_mbr),
    .id_o     (obj_id)
  );

  always_comb begin
    for (int i = 0; i < N_OBJ; i++) begin
      ded_req[i] = obj_en[i] && !obj_dir[i] && !obj_mbr[i] && (obj_id[i] == rx_id_i);
      mbr_req[i] = obj_en[i] && !obj_dir[i] && obj_mbr[i];
      tx_rq[i]   = obj_en[i] && obj_dir[i];
    end
  end

  can_mob_prio #(.N(N_OBJ), .IW(IW)) u_ded (
    .req_i(ded_req), .any_o(ded_any), .idx_o(ded_idx), .gnt_o(ded_gnt));
  can_mob_prio #(.N(N_OBJ), .IW(IW)) u_mbr (
    .req_i(mbr_req), .any_o(mbr_any), .idx_o(mbr_idx), .gnt_o(mbr_gnt));
  can_mob_prio #(.N(N_OBJ), .IW(IW)) u_tx (
    .req_i(tx_rq), .any_o(tx_any), .idx_o(tx_idx), .gnt_o(tx_gnt));

  assign rx_take  = rx_done_i && (ded_any || mbr_any);
  assign rx_idx   = ded_any ? ded_idx : mbr_idx;
  // last enabled member consumed
  assign fill_evt = rx_done_i && !ded_any && mbr_any && ((mbr_req & ~mbr_gnt) == '0);
  assign tx_clr   = tx_done_i && tx_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q     <= '0;
      glb_en_q   <= 1'b0;
      irq_q      <= 1'b0;
      stamp_q    <= '0;
      rx_store_o <= 1'b0;
      rx_obj_o   <= '0;
    end else begin
      if (wr_page) page_q <= wr_data_i[IW-1:0];
      if (wr_glb)  glb_en_q <= wr_data_i[GB_EN];
      if (fill_evt)                        irq_q <= 1'b1;
      else if (wr_glb && wr_data_i[GB_IRQ]) irq_q <= 1'b0;
      if (rx_done_i || tx_clr) stamp_q <= ts;
      rx_store_o <= rx_take;
      if (rx_take) rx_obj_o <= rx_idx;
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_PAGE:  rd_data_o = DW'(page_q);
      A_CTRL:  rd_data_o = DW'({obj_mbr[page_q], obj_dir[page_q], obj_en[page_q]});
      A_ID:    rd_data_o = DW'(obj_id[page_q]);
      A_GLB:   rd_data_o = DW'({irq_q, glb_en_q});
      A_STMP:  rd_data_o = DW'(stamp_q);
      A_TIME:  rd_data_o = DW'(ts);
      default: rd_data_o = '0;
    endcase
  end

  assign tx_req_o = tx_any;
  assign tx_obj_o = tx_idx;
  assign tx_id_o  = obj_id[tx_idx];
  assign irq_o    = irq_q;
endmodule

// File: rtl/can_mob_chk.sv
`timescale 1ns/1ps
module can_mob_chk #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2,
  parameter int unsigned TW = 16,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          glb_en,
  input logic [TW-1:0] ts,
  input logic          irq_o,
  input logic          wr_en_i,
  input logic [2:0]    wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          rx_store_o,
  input logic [IW-1:0] rx_obj_o,
  input logic [N-1:0]  obj_en,
  input logic [N-1:0]  obj_dir,
  input logic          tx_req_o,
  input logic [IW-1:0] tx_obj_o,
  input logic          fill_evt
);
  logic [N-1:0] lo_mask;
  logic         irq_clr;
  assign lo_mask = (N'(1) << tx_obj_o) - N'(1);
  assign irq_clr = wr_en_i && (wr_addr_i == 3'd3) && wr_data_i[1];

  p_ts_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en |=> ts == '0);
  p_ts_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glb_en |=> ts == TW'($past(ts) + TW'(1)));
  p_irq_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr |=> irq_o);
  p_irq_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(fill_evt));
  p_rx_disable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_store_o && !$past(wr_en_i) |-> !obj_en[rx_obj_o]);
  p_tx_lowest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> obj_en[tx_obj_o] && obj_dir[tx_obj_o] && ((obj_en & obj_dir & lo_mask) == '0));
  p_tx_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_req_o |-> (obj_en & obj_dir) == '0);
endmodule

bind can_mob_alloc can_mob_chk #(.N(N_OBJ), .IW(IW), .TW(TW), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .glb_en    (glb_en_q),
  .ts        (ts),
  .irq_o     (irq_o),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .rx_store_o(rx_store_o),
  .rx_obj_o  (rx_obj_o),
  .obj_en    (obj_en),
  .obj_dir   (obj_dir),
  .tx_req_o  (tx_req_o),
  .tx_obj_o  (tx_obj_o),
  .fill_evt  (fill_evt)
);

// File: tb/tb_can_mob_alloc.sv
`timescale 1ns/1ps
module tb_can_mob_alloc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        rx_done_i = 1'b0;
  logic [10:0] rx_id_i = '0;
  logic        rx_store_o;
  logic [1:0]  rx_obj_o;
  logic        tx_req_o;
  logic [1:0]  tx_obj_o;
  logic [10:0] tx_id_o;
  logic        tx_done_i = 1'b0;
  logic        irq_o;

  int n_vec = 0;
  int n_err = 0;
  int exp_q[$];

  always #2.5 clk_i = ~clk_i;

  can_mob_alloc dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .rx_done_i(rx_done_i), .rx_id_i(rx_id_i),
    .rx_store_o(rx_store_o), .rx_obj_o(rx_obj_o),
    .tx_req_o(tx_req_o), .tx_obj_o(tx_obj_o), .tx_id_o(tx_id_o),
    .tx_done_i(tx_done_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    rd_addr_i = a;
    #0.5;
    d = int'(rd_data_o);
  endtask

  task automatic obj_cfg(input int obj, input logic [2:0] ctrl, input logic [10:0] id);
    wr(3'd0, 16'(obj));
    wr(3'd2, 16'(id));
    wr(3'd1, 16'(ctrl));
  endtask

  task automatic obj_rd(input int obj, output int ctrl, output int id);
    wr(3'd0, 16'(obj));
    rd(3'd1, ctrl);
    rd(3'd2, id);
  endtask

  // exp < 0 : frame must be dropped
  task automatic send_rx(input logic [10:0] id, input int exp, input string req);
    if (exp >= 0) exp_q.push_back(exp);
    rx_id_i = id; rx_done_i = 1'b1;
    @(negedge clk_i);
    rx_done_i = 1'b0;
    if (exp < 0) chk({req, " drop"}, int'(rx_store_o), 0);
    @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && rx_store_o) begin
      if (exp_q.size() == 0) chk("R7 unexpected store", int'(rx_obj_o), -1);
      else chk("R5/R6/R7 stored object", int'(rx_obj_o), exp_q.pop_front());
    end
  end

  task automatic finish_run();
    chk("R7 scoreboard empty", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    int v, c, id, t;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(3'd0, v); chk("R1 page", v, 0);
    rd(3'd1, v); chk("R1 ctrl obj0", v, 0);
    rd(3'd3, v); chk("R1 global", v, 0);
    rd(3'd5, v); chk("R1 timer", v, 0);
    chk("R1 tx_req", int'(tx_req_o), 0);
    chk("R1 irq", int'(irq_o), 0);

    // R3 timer held while disabled
    repeat (5) @(negedge clk_i);
    rd(3'd5, v); chk("R3 timer held", v, 0);

    // R2 config: members 0,2; dedicated 1; tx 3
    obj_cfg(0, 3'b101, 11'h000);
    obj_cfg(1, 3'b001, 11'h123);
    obj_cfg(2, 3'b101, 11'h000);
    obj_cfg(3, 3'b011, 11'h055);
    wr(3'd0, 16'd3);
    rd(3'd0, v); chk("R2 page readback", v, 3);
    rd(3'd1, v); chk("R2 ctrl readback", v, 3);
    chk("R10 tx_req", int'(tx_req_o), 1);
    chk("R10 tx_obj", int'(tx_obj_o), 3);
    chk("R10 tx_id", int'(tx_id_o), 'h055);

    // R3 timer runs
    wr(3'd3, 16'h1);
    repeat (3) @(negedge clk_i);
    rd(3'd5, t);
    @(negedge clk_i);
    rd(3'd5, v); chk("R3 timer step", v, (t + 1) & 'hFFFF);

    // R5 dedicated beats lower member
    send_rx(11'h123, 1, "R5");
    obj_rd(1, c, id);
    chk("R7 ded disabled", c, 0);
    chk("R7 ded id", id, 'h123);
    chk("R11 no irq on dedicated", int'(irq_o), 0);

    // R6 + R4 member 0 with stamp
    rd(3'd5, t);
    send_rx(11'h200, 0, "R6");
    rd(3'd4, v); chk("R4 rx stamp", v, t);
    obj_rd(0, c, id);
    chk("R7 member0 disabled", c, 3'b100);
    chk("R7 member0 id", id, 'h200);
    chk("R8 irq not yet", int'(irq_o), 0);

    // R6 skip gap to member 2, R8 full
    send_rx(11'h201, 2, "R6");
    chk("R8 irq set", int'(irq_o), 1);

    // R9 dropped while full
    send_rx(11'h300, -1, "R9");
    obj_rd(2, c, id);
    chk("R9 member2 id kept", id, 'h201);
    chk("R9 member2 ctrl kept", c, 3'b100);

    // R11 dedicated still works while full
    obj_cfg(1, 3'b001, 11'h123);
    send_rx(11'h123, 1, "R11");
    chk("R8 irq still set", int'(irq_o), 1);

    // R8 clear
    wr(3'd3, 16'h3);
    chk("R8 irq cleared", int'(irq_o), 0);
    rd(3'd3, v); chk("R8 global after clear", v, 1);
    send_rx(11'h301, -1, "R9");
    chk("R11 ded refill no irq", int'(irq_o), 0);

    // R9 re-enable member 2 only
    wr(3'd0, 16'd2);
    wr(3'd1, 16'h5);
    send_rx(11'h400, 2, "R9");
    chk("R8 irq again", int'(irq_o), 1);
    wr(3'd3, 16'h3);

    // R10 + R4 tx done
    rd(3'd5, t);
    tx_done_i = 1'b1;
    @(negedge clk_i);
    tx_done_i = 1'b0;
    chk("R10 tx cleared", int'(tx_req_o), 0);
    rd(3'd4, v); chk("R4 tx stamp", v, t);

    // R10 two pending, lowest first
    obj_cfg(1, 3'b011, 11'h0AA);
    obj_cfg(0, 3'b011, 11'h010);
    chk("R10 lowest tx", int'(tx_obj_o), 0);
    chk("R10 lowest tx id", int'(tx_id_o), 'h010);
    tx_done_i = 1'b1;
    @(negedge clk_i);
    tx_done_i = 1'b0;
    chk("R10 next tx", int'(tx_obj_o), 1);
    chk("R10 next tx id", int'(tx_id_o), 'h0AA);
    chk("R10 still pending", int'(tx_req_o), 1);

    // R3 wrap
    rd(3'd5, t);
    repeat (16'hFFFF - t) @(negedge clk_i);
    rd(3'd5, v); chk("R3 timer top", v, 'hFFFF);
    @(negedge clk_i);
    rd(3'd5, v); chk("R3 timer wrap", v, 0);

    // R3 disable returns to zero
    wr(3'd3, 16'h0);
    @(negedge clk_i);
    rd(3'd5, v); chk("R3 timer zero off", v, 0);

    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule